// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Wake-Up Framing

This block turns bytes into asynchronous serial frames on a single line that idles high. A one-deep holding buffer accepts a character on a write strobe. The character then moves into a shift register and goes out least significant bit first. The bit rate comes from an internal divider driven by a 16-bit divisor. A set of format inputs selects the character length, parity, stop bit count and multiprocessor wake-up mode. These inputs are sampled when a character moves into the shift register.

Two flags serve a polling or interrupt layer above the block:
- The ready flag shows that the holding buffer can take the next character while the current one is still shifting.
- The empty flag shows that both stages are drained.

A one-shot wake request marks the next frame as an address frame. In idle-line mode it does this with a fixed idle gap before the frame. In address-bit mode it does this by setting an extra bit inside the frame.

Top module: `uart_tx_wake`

## Requirements
- R1: After reset `txd`, `tx_rdy` and `tx_empty` are all 1.
- R2: A bit lasts 8 × (`baud_div` + 1) clocks when `baud_div` is 1 or more, and 16 clocks when `baud_div` is 0. The tick divider has period `baud_div` + 1, or 2 when `baud_div` is 0, and one bit is 8 ticks.
- R3: A frame is sent in this order:
  - a low start bit;
  - `char_len` + 1 data bits, LSB first;
  - the address bit, only when `addr_mode` = 1;
  - the parity bit, only when `par_en` = 1;
  - one high stop bit, or two when `two_stop` = 1.

  The start bit begins on the clock edge that moves the character out of the buffer.
- R4: The parity bit covers only the data bits. With `par_even` = 1 it makes the count of ones in data plus parity even. With `par_even` = 0 it makes that count odd.
- R5: `tx_rdy` drops on the clock edge after a write. It rises on the edge that moves the character into the shift register, which is the next edge if the shifter is idle. If the shifter is busy, the move happens one clock after the running frame's last stop bit ends.
- R6: `tx_empty` drops on the clock edge after a write. It is 1 only when the buffer and the shift register are both empty, which is from the edge that ends the last stop bit.
- R7: In idle-line mode (`addr_mode` = 0), a pending wake request makes the line stay high for exactly 11 bit times after the character moves into the shift register, before the start bit.
- R8: In address-bit mode (`addr_mode` = 1), a pending wake request sets the frame's address bit to 1. Without a pending request the address bit is 0.
- R9: A wake request set by a pulse on `wake_set` applies to the next frame only. It is cleared when that frame is loaded.
- R10: While `tx_en` = 0, the block holds `txd` high and empties the buffer and the shift register. It also ignores writes and wake requests, and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable; 0 holds and clears the transmitter |
| baud_div | input | 16 | Bit-rate divisor |
| char_len | input | 3 | Data bits minus one |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | 1 adds a parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| addr_mode | input | 1 | 0 idle-line wake-up, 1 address-bit wake-up |
| wake_set | input | 1 | Pulse that marks the next frame as an address frame |
| wr | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Buffer empty |
| tx_empty | output | 1 | Buffer and shift register both empty |

## Verification
Each flag update is due on the clock edge that registers the write. `tx_rdy` recovers one edge later for an idle shifter. The start bit, or the 11-bit idle gap, also begins on that later edge. The bench drives inputs on falling edges and counts falling edges from that load edge. It checks the line on the first and last clock of every expected bit, so a bit one clock too short or too long is caught. A back-to-back write checks the single idle clock between frames, and the flags are checked on the exact edge that ends the last stop bit.

// File: rtl/uart_tx_wake.sv
module uart_tx_wake #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [2:0]        char_len,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              addr_mode,
  input  logic              wake_set,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_empty
);
  localparam int GAP  = 11;
  localparam int FRMW = DATA_W + 5;
  localparam int SHW  = FRMW + GAP;
  localparam int BLW  = $clog2(SHW + 1);

  logic              buf_full, busy, wake;
  logic [DATA_W-1:0] buf_data;
  logic [SHW-1:0]    shreg, shl;
  logic [BLW-1:0]    left, nb;
  logic [DIV_W-1:0]  bcnt, lim;
  logic [2:0]        sub;
  logic [FRMW-1:0]   frm, dext;
  logic              load, tick, gap, parx;

  assign lim      = (baud_div == '0) ? DIV_W'(1) : baud_div;
  assign tick     = busy && (bcnt == lim);
  assign load     = buf_full && !busy;
  assign gap      = wake && !addr_mode;
  assign dext     = FRMW'(buf_data);
  assign txd      = busy ? shreg[0] : 1'b1;
  assign tx_rdy   = !buf_full;
  assign tx_empty = !buf_full && !busy;

  always_comb begin
    int dl, ap, pp, sp;
    dl   = int'(char_len) + 1;
    ap   = dl + 1;
    pp   = ap + (addr_mode ? 1 : 0);
    sp   = pp + (par_en ? 1 : 0);
    parx = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < dl) parx = parx ^ buf_data[i];
    frm    = '1;
    frm[0] = 1'b0;
    for (int j = 1; j < FRMW; j++) begin
      if (j <= dl)                    frm[j] = dext[j-1];
      else if (addr_mode && j == ap)  frm[j] = wake;
      else if (par_en && j == pp)     frm[j] = par_even ? parx : !parx;
    end
    shl = gap ? {frm, {GAP{1'b1}}} : {{GAP{1'b1}}, frm};
    nb  = BLW'(sp + 1 + (two_stop ? 1 : 0) + (gap ? GAP : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0; buf_data <= '0; busy <= 1'b0; wake <= 1'b0;
      shreg <= '1; left <= '0; bcnt <= '0; sub <= '0;
    end else if (!tx_en) begin
      buf_full <= 1'b0; busy <= 1'b0; wake <= 1'b0;
      bcnt <= '0; sub <= '0;
    end else begin
      wake <= wake_set || (wake && !load);
      if (wr) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
      end else if (load) begin
        buf_full <= 1'b0;
      end
      if (load) begin
        busy <= 1'b1; shreg <= shl; left <= nb; bcnt <= '0; sub <= '0;
      end else if (busy) begin
        if (tick) begin
          bcnt <= '0;
          sub  <= sub + 3'd1;
          if (sub == 3'd7) begin
            shreg <= {1'b1, shreg[SHW-1:1]};
            left  <= left - BLW'(1);
            if (left == BLW'(1)) busy <= 1'b0;
          end
        end else begin
          bcnt <= bcnt + DIV_W'(1);
        end
      end
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(tx_en) |-> $past(txd));
  p_rdy_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) && $past(tx_en) |-> busy);
  p_empty_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && tx_en |=> !tx_empty);
  p_wake_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load && !wake_set |=> !wake);
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd && tx_empty && tx_rdy);
endmodule

// File: tb/uart_tx_wake_test.sv
`timescale 1ns/1ps
module uart_tx_wake_test;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
  logic [15:0] baud_div = '0;
  logic [2:0] char_len = 3'd7;
  logic two_stop = 0, par_en = 0, par_even = 0, addr_mode = 0, wake_set = 0, wr = 0;
  logic [7:0] wr_data = '0;
  logic txd, tx_rdy, tx_empty;
  int chk = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_tx_wake uut (.clk, .rst_n, .tx_en, .baud_div, .char_len, .two_stop, .par_en,
    .par_even, .addr_mode, .wake_set, .wr, .wr_data, .txd, .tx_rdy, .tx_empty);

  task automatic check(input string req, input int act, input int exp);
    chk++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bit_clks();
    return 8 * ((baud_div == 0) ? 2 : int'(baud_div) + 1);
  endfunction

  task automatic build(input logic [7:0] d, input bit gp, input bit ab,
                       output logic [31:0] v, output int len);
    int idx, dl;
    bit p;
    v = '1; idx = gp ? 11 : 0; dl = int'(char_len) + 1; p = 0;
    v[idx] = 0; idx++;
    for (int i = 0; i < dl; i++) begin v[idx] = d[i]; p ^= d[i]; idx++; end
    if (addr_mode) begin v[idx] = ab; idx++; end
    if (par_en) begin v[idx] = par_even ? p : !p; idx++; end
    idx += two_stop ? 2 : 1;
    len = idx;
  endtask

  task automatic wr_char(input logic [7:0] d);
    @(negedge clk); wr = 1; wr_data = d;
    @(negedge clk); wr = 0;
  endtask

  // starts at the falling edge just after the load edge (m = 0)
  task automatic watch(input logic [31:0] v, input int len, input string req);
    int b = bit_clks();
    check("R5 tx_rdy high after load", tx_rdy, 1);
    for (int m = 0; m <= len * b; m++) begin
      if (m < len * b) begin
        if ((m % b) == 0 || (m % b) == b - 1) check(req, txd, v[m / b]);
        if (m == 0) check("R6 tx_empty low while shifting", tx_empty, 0);
        @(negedge clk);
      end else begin
        check("R6 tx_empty after last stop", tx_empty, 1);
        check("R3 line high after frame", txd, 1);
      end
    end
  endtask

  task automatic send(input logic [7:0] d, input bit gp, input bit ab, input string req);
    logic [31:0] v; int len;
    build(d, gp, ab, v, len);
    wr_char(d);
    check("R5 tx_rdy low after write", tx_rdy, 0);
    check("R6 tx_empty low after write", tx_empty, 0);
    @(negedge clk);
    watch(v, len, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk++; bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", chk - bad, chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, vb; int la, lb, b;
    repeat (3) @(negedge clk);
    check("R1 txd", txd, 1); check("R1 tx_rdy", tx_rdy, 1); check("R1 tx_empty", tx_empty, 1);
    rst_n = 1; @(negedge clk);
    check("R1 txd after release", txd, 1);
    tx_en = 1;

    // R2 R3 R4: sweep of formats and divisors
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      char_len  = 3'(c % 8);
      par_en    = ((c / 8) % 3) != 0;
      par_even  = ((c / 8) % 3) == 2;
      two_stop  = ((c / 24) % 2) == 1;
      addr_mode = (c / 48) == 1;
      case ((c / 3) % 4)
        0: baud_div = 16'd0;
        1: baud_div = 16'd1;
        2: baud_div = 16'd2;
        default: baud_div = 16'd5;
      endcase
      send(8'(8'hA5 ^ (c * 37)), 0, 0, "R2 R3 R4 frame bit");
    end

    // R8 and R9 in address-bit mode
    @(negedge clk);
    baud_div = 16'd1; char_len = 3'd7; par_en = 1; par_even = 1; two_stop = 0; addr_mode = 1;
    wake_set = 1; @(negedge clk); wake_set = 0;
    send(8'h3C, 0, 1, "R8 address frame");
    send(8'h3C, 0, 0, "R9 wake cleared after one frame");

    // R7 and R9 in idle-line mode
    @(negedge clk);
    addr_mode = 0; par_en = 0; baud_div = 16'd0;
    wake_set = 1; @(negedge clk); wake_set = 0;
    send(8'h81, 1, 0, "R7 idle gap then frame");
    send(8'h81, 0, 0, "R9 no gap on following frame");

    // R5: back-to-back characters
    baud_div = 16'd2; char_len = 3'd4; two_stop = 1;
    b = bit_clks();
    build(8'h15, 0, 0, va, la);
    build(8'h0A, 0, 0, vb, lb);
    wr_char(8'h15);
    @(negedge clk);
    check("R5 first load", tx_rdy, 1);
    wr_char(8'h0A);
    check("R5 tx_rdy low with second queued", tx_rdy, 0);
    check("R3 first start bit", txd, 0);
    repeat (la * b - 2) @(negedge clk);
    check("R5 second still queued at end of first", tx_rdy, 0);
    check("R6 not empty with queued char", tx_empty, 0);
    check("R3 idle clock between frames", txd, 1);
    @(negedge clk);
    watch(vb, lb, "R5 second frame bit");

    // R10: disable mid-frame, write and wake while disabled
    wr_char(8'h00);
    repeat (20) @(negedge clk);
    check("R10 frame running", txd, 0);
    tx_en = 0; @(negedge clk);
    check("R10 txd high when disabled", txd, 1);
    check("R10 tx_rdy when disabled", tx_rdy, 1);
    check("R10 tx_empty when disabled", tx_empty, 1);
    wr = 1; wr_data = 8'h55; wake_set = 1; @(negedge clk); wr = 0; wake_set = 0;
    tx_en = 1;
    repeat (3) @(negedge clk);
    check("R10 write ignored: empty", tx_empty, 1);
    check("R10 write ignored: line", txd, 1);
    addr_mode = 1;
    send(8'h66, 0, 0, "R10 wake ignored while disabled");

    done = 1;
    $display("%0d/%0d checks passed", chk - bad, chk);
    $finish;
  end
endmodule